// File: doc/BRIEF.md
# Reservation Monitor with Bounded Exclusive Hold

This block tracks one load-linked reservation for one core and decides whether the matching store-conditional succeeds. It sits next to the core's private cache controller. Snoops and forwards from the coherence fabric pass through it on their way to that controller. When the core takes a reservation on a line it holds exclusively, the block holds back a snoop aimed at that line. The core can then finish its read-modify-write without interference from other cores, so this one thread is guaranteed to make progress.

The hold is always bounded. A programmable count of cycles starts at the load-linked, and when it runs out the reservation is dropped and any held snoop is released. Only one snoop can be held. Any later snoop is refused through a registered stall signal until the held one is released.

A reservation taken on a line held only in the shared state gives no protection. A snoop that kills the line ends such a reservation at once. All addresses on the block's ports are line addresses.

Top module: `llsc_pin_monitor`

## Requirements
- R1: After reset, sc_done, sc_ok, snp_stall and snp_out_valid are all 0.
- R2: core_op encoding: 2'b00 idle, 2'b01 load-linked, 2'b10 store-conditional, 2'b11 plain store. A store-conditional to the reserved line while the reservation is valid reports sc_done=1 with sc_ok=1 in the cycle after it is sampled. A store-conditional to any other line, or with no reservation, reports sc_ok=0. Every store-conditional clears the reservation, so a second one fails.
- R3: A load-linked with core_excl=1 pins the line. An accepted snoop to the pinned line, whether kill or downgrade, is held and does not appear on snp_out until the pin is released. It appears in the cycle after the release edge.
- R4: With hold limit N = cfg_hold_cycles (0 counts as 1), sampled at the load-linked, a store-conditional sampled at the N-th edge after the load-linked succeeds and one at edge N+1 fails. Expiry releases a held snoop.
- R5: While a snoop is held, snp_stall=1 and no further snoop is accepted. A snoop is taken when snp_valid=1 and snp_stall=0. snp_stall returns to 0 in the cycle after the release edge.
- R6: A load-linked while a reservation exists replaces it: the old line no longer satisfies a store-conditional, and a held snoop is released.
- R7: A store-conditional to a pinned line succeeds even if a kill snoop (snp_kill=1) to that line is sampled at the same edge. That snoop goes straight to snp_out in the next cycle without raising snp_stall.
- R8: A plain store to the reserved line clears the reservation and produces no store-conditional result. A plain store to another line leaves the reservation intact.
- R9: Without a pin (core_excl=0 at the load-linked), a kill snoop to the reserved line passes out in the next cycle and clears the reservation, including against a store-conditional sampled at the same edge. A downgrade snoop (snp_kill=0) leaves the reservation valid.
- R10: Snoops to lines other than the reserved one pass out in the next cycle even while a pin is active, and do not disturb the reservation.
- R11: A kill snoop leaving the block at the same edge as a load-linked to that same line leaves no valid reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hold_cycles | input | HOLD_W | Hold limit in cycles, sampled at each load-linked |
| core_op | input | 2 | Core request: idle, load-linked, store-conditional, plain store |
| core_line | input | LINE_W | Line address of the core request |
| core_excl | input | 1 | Line is held Exclusive/Modified at the load-linked |
| snp_valid | input | 1 | Incoming snoop or forward present |
| snp_line | input | LINE_W | Line address of the incoming snoop |
| snp_kill | input | 1 | 1 = invalidate/ownership transfer, 0 = downgrade to shared |
| snp_stall | output | 1 | Registered; snoops are refused while high |
| snp_out_valid | output | 1 | Snoop delivered to the cache controller |
| snp_out_line | output | LINE_W | Line address of the delivered snoop |
| snp_out_kill | output | 1 | Kind of the delivered snoop |
| sc_done | output | 1 | Store-conditional result strobe |
| sc_ok | output | 1 | Store-conditional succeeded (valid with sc_done) |

## Verification
The hardest situations to reach are collisions at a single edge, where a snoop to the reserved line arrives at the same edge as a store-conditional, a new load-linked or the expiry edge. The outcome then depends on which of them is given priority. The stimulus drives the core request and the snoop on the same falling edge, so both are sampled together, with and without a pin. A second snoop is held against an active stall until the hold count runs out, to show that exactly one is buffered and that the second is taken only after the release.

// File: rtl/llsc_pkg.sv
`timescale 1ns/1ps
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_LL   = 2'b01,
    OP_SC   = 2'b10,
    OP_ST   = 2'b11
  } core_op_e;
endpackage

// File: rtl/llsc_hold_timer.sv
`timescale 1ns/1ps
module llsc_hold_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [HOLD_W-1:0] load_val,
  input  logic              run,
  output logic              expire
);
  localparam logic [HOLD_W-1:0] ONE = {{(HOLD_W-1){1'b0}}, 1'b1};

  logic [HOLD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (load_val == '0) ? ONE : load_val;
    end else if (run && (cnt > ONE)) begin
      cnt <= cnt - ONE;
    end
  end

  assign expire = run && (cnt == ONE);

  AST_CNT_LOADED: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt != '0)); // R4
endmodule

// File: rtl/llsc_snoop_gate.sv
`timescale 1ns/1ps
module llsc_snoop_gate #(
  parameter int LINE_W = 26
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_valid,
  input  logic [LINE_W-1:0] snp_line,
  input  logic              snp_kill,
  input  logic              pin,
  input  logic [LINE_W-1:0] resv_line,
  input  logic              pin_drop,
  output logic              snp_stall,
  output logic              snp_out_valid,
  output logic [LINE_W-1:0] snp_out_line,
  output logic              snp_out_kill,
  output logic              evt_valid,
  output logic [LINE_W-1:0] evt_line,
  output logic              evt_kill
);
  logic              hold_v;
  logic [LINE_W-1:0] hold_line;
  logic              hold_kill;
  logic              take, defer, pass, rel, hold_v_n;

  assign take  = snp_valid && !snp_stall;
  assign defer = take && pin && !pin_drop && (snp_line == resv_line);
  assign pass  = take && !defer;
  assign rel   = hold_v && pin_drop;

  assign evt_valid = rel || pass;
  assign evt_line  = rel ? hold_line : snp_line;
  assign evt_kill  = rel ? hold_kill : snp_kill;

  always_comb begin
    hold_v_n = hold_v;
    if (defer)    hold_v_n = 1'b1;
    else if (rel) hold_v_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v        <= 1'b0;
      hold_line     <= '0;
      hold_kill     <= 1'b0;
      snp_stall     <= 1'b0;
      snp_out_valid <= 1'b0;
      snp_out_line  <= '0;
      snp_out_kill  <= 1'b0;
    end else begin
      hold_v        <= hold_v_n;
      snp_stall     <= hold_v_n;
      snp_out_valid <= evt_valid;
      if (defer) begin
        hold_line <= snp_line;
        hold_kill <= snp_kill;
      end
      if (evt_valid) begin
        snp_out_line <= evt_line;
        snp_out_kill <= evt_kill;
      end
    end
  end

  AST_ONE_SNOOP_OUT: assert property (@(posedge clk) disable iff (rst)
    !(rel && pass)); // R5
  AST_DEFER_STALLS: assert property (@(posedge clk) disable iff (rst)
    defer |=> (snp_stall && !snp_out_valid)); // R5
  AST_HELD_ONLY_PINNED: assert property (@(posedge clk) disable iff (rst)
    hold_v |-> pin); // R3
endmodule

// File: rtl/llsc_resv_ctrl.sv
`timescale 1ns/1ps
module llsc_resv_ctrl
  import llsc_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HOLD_W-1:0] cfg_hold_cycles,
  input  logic [1:0]        core_op,
  input  logic [LINE_W-1:0] core_line,
  input  logic              core_excl,
  input  logic              evt_valid,
  input  logic [LINE_W-1:0] evt_line,
  input  logic              evt_kill,
  output logic              pin,
  output logic [LINE_W-1:0] resv_line,
  output logic              pin_drop,
  output logic              sc_done,
  output logic              sc_ok
);
  core_op_e op;
  logic resv_v, excl, expire;
  logic is_ll, is_sc, st_hit, line_hit, evt_on_resv, kill_hit, dn_hit;
  logic evt_on_ll, sc_win;

  assign op          = core_op_e'(core_op);
  assign is_ll       = (op == OP_LL);
  assign is_sc       = (op == OP_SC);
  assign line_hit    = resv_v && (core_line == resv_line);
  assign st_hit      = (op == OP_ST) && line_hit;
  assign evt_on_resv = evt_valid && resv_v && (evt_line == resv_line);
  assign kill_hit    = evt_on_resv && evt_kill;
  assign dn_hit      = evt_on_resv && !evt_kill;
  assign evt_on_ll   = evt_valid && (evt_line == core_line);
  assign sc_win      = line_hit && (pin || !kill_hit);

  assign pin      = resv_v && excl;
  assign pin_drop = pin && (is_ll || is_sc || st_hit || expire);

  llsc_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (is_ll),
    .load_val (cfg_hold_cycles),
    .run      (resv_v),
    .expire   (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resv_v    <= 1'b0;
      excl      <= 1'b0;
      resv_line <= '0;
      sc_done   <= 1'b0;
      sc_ok     <= 1'b0;
    end else begin
      sc_done <= is_sc;
      sc_ok   <= is_sc && sc_win;
      if (is_ll) begin
        resv_line <= core_line;
        resv_v    <= !(evt_on_ll && evt_kill);
        excl      <= core_excl && !evt_on_ll;
      end else if (is_sc || st_hit || expire || kill_hit) begin
        resv_v <= 1'b0;
        excl   <= 1'b0;
      end else if (dn_hit) begin
        excl <= 1'b0;
      end
    end
  end

  AST_EXPIRE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (expire && !is_ll) |=> !resv_v); // R4
  AST_PIN_SC_OK: assert property (@(posedge clk) disable iff (rst)
    (is_sc && pin && (core_line == resv_line)) |=> (sc_done && sc_ok)); // R7
  AST_SC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    is_sc |=> (sc_done && !resv_v)); // R2
  AST_STORE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ST) |=> !sc_done); // R8
endmodule

// File: rtl/llsc_pin_monitor.sv
`timescale 1ns/1ps
module llsc_pin_monitor #(
  parameter int LINE_W = 26,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HOLD_W-1:0] cfg_hold_cycles,
  input  logic [1:0]        core_op,
  input  logic [LINE_W-1:0] core_line,
  input  logic              core_excl,
  input  logic              snp_valid,
  input  logic [LINE_W-1:0] snp_line,
  input  logic              snp_kill,
  output logic              snp_stall,
  output logic              snp_out_valid,
  output logic [LINE_W-1:0] snp_out_line,
  output logic              snp_out_kill,
  output logic              sc_done,
  output logic              sc_ok
);
  logic              pin, pin_drop;
  logic [LINE_W-1:0] resv_line;
  logic              evt_valid, evt_kill;
  logic [LINE_W-1:0] evt_line;

  llsc_resv_ctrl #(.LINE_W(LINE_W), .HOLD_W(HOLD_W)) u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .cfg_hold_cycles (cfg_hold_cycles),
    .core_op         (core_op),
    .core_line       (core_line),
    .core_excl       (core_excl),
    .evt_valid       (evt_valid),
    .evt_line        (evt_line),
    .evt_kill        (evt_kill),
    .pin             (pin),
    .resv_line       (resv_line),
    .pin_drop        (pin_drop),
    .sc_done         (sc_done),
    .sc_ok           (sc_ok)
  );

  llsc_snoop_gate #(.LINE_W(LINE_W)) u_gate (
    .clk           (clk),
    .rst           (rst),
    .snp_valid     (snp_valid),
    .snp_line      (snp_line),
    .snp_kill      (snp_kill),
    .pin           (pin),
    .resv_line     (resv_line),
    .pin_drop      (pin_drop),
    .snp_stall     (snp_stall),
    .snp_out_valid (snp_out_valid),
    .snp_out_line  (snp_out_line),
    .snp_out_kill  (snp_out_kill),
    .evt_valid     (evt_valid),
    .evt_line      (evt_line),
    .evt_kill      (evt_kill)
  );

  AST_STALL_NO_OUTPUT_DUP: assert property (@(posedge clk) disable iff (rst)
    (snp_stall && $past(snp_stall) && !pin) |-> !evt_valid); // R5
endmodule

// File: tb/sim_llsc_pin_monitor.sv
`timescale 1ns/1ps
module sim_llsc_pin_monitor;
  localparam int LW = 26;
  localparam int HW = 8;
  localparam logic [1:0] IDLE = 2'b00, LL = 2'b01, SC = 2'b10, ST = 2'b11;
  localparam logic [LW-1:0] LA = 26'h0000040, LB = 26'h0000080, LC = 26'h00000C0;

  logic clk = 1'b0, rst = 1'b1;
  logic [HW-1:0] cfg_hold_cycles = 8'd40;
  logic [1:0]    core_op = IDLE;
  logic [LW-1:0] core_line = '0, snp_line = '0, snp_out_line;
  logic core_excl = 1'b0, snp_valid = 1'b0, snp_kill = 1'b0;
  logic snp_stall, snp_out_valid, snp_out_kill, sc_done, sc_ok;
  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  llsc_pin_monitor #(.LINE_W(LW), .HOLD_W(HW)) u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic idle_all();
    core_op = IDLE; core_excl = 1'b0; snp_valid = 1'b0; snp_kill = 1'b0;
  endtask
  task automatic core(input logic [1:0] op, input logic [LW-1:0] ln, input logic ex);
    core_op = op; core_line = ln; core_excl = ex;
  endtask
  task automatic snp(input logic [LW-1:0] ln, input logic k);
    snp_valid = 1'b1; snp_line = ln; snp_kill = k;
  endtask
  task automatic sc_expect(input logic [LW-1:0] ln, input logic ok, input string tag);
    core(SC, ln, 1'b0); tick(); idle_all();
    chk({tag, " sc_done"}, sc_done, 1'b1);
    chk({tag, " sc_ok"}, sc_ok, ok);
    tick();
  endtask

  task automatic t_reset();
    chk("R1 sc_done", sc_done, 0); chk("R1 sc_ok", sc_ok, 0);
    chk("R1 stall", snp_stall, 0); chk("R1 out_valid", snp_out_valid, 0);
  endtask

  task automatic t_basic();
    core(LL, LA, 1'b0); tick(); idle_all(); tick();
    sc_expect(LA, 1'b1, "R2 match");
    sc_expect(LA, 1'b0, "R2 second");
    core(LL, LA, 1'b1); tick(); idle_all();
    sc_expect(LB, 1'b0, "R2 other line");
    sc_expect(LA, 1'b0, "R2 cleared by miss");
  endtask

  task automatic t_pin_defer();
    core(LL, LA, 1'b1); tick(); idle_all();
    snp(LA, 1'b1); tick(); idle_all();
    chk("R3 held", snp_out_valid, 0); chk("R5 stall up", snp_stall, 1);
    tick(); tick();
    chk("R3 still held", snp_out_valid, 0);
    core(SC, LA, 1'b0); tick(); idle_all();
    chk("R3 sc_ok", sc_ok, 1);
    chk("R3 released", snp_out_valid, 1);
    chk("R3 line", snp_out_line, LA); chk("R3 kind", snp_out_kill, 1);
    chk("R5 stall down", snp_stall, 0);
    tick(); chk("R3 single out", snp_out_valid, 0);
  endtask

  task automatic t_window();
    cfg_hold_cycles = 8'd3;
    core(LL, LA, 1'b1); tick(); idle_all(); tick(); tick();
    sc_expect(LA, 1'b1, "R4 edge N");
    core(LL, LA, 1'b1); tick(); idle_all(); tick(); tick(); tick();
    sc_expect(LA, 1'b0, "R4 edge N+1");
    cfg_hold_cycles = 8'd0;
    core(LL, LA, 1'b1); tick(); idle_all();
    sc_expect(LA, 1'b1, "R4 zero edge1");
    core(LL, LA, 1'b1); tick(); idle_all(); tick();
    sc_expect(LA, 1'b0, "R4 zero edge2");
    cfg_hold_cycles = 8'd40;
  endtask

  task automatic t_expiry_backpressure();
    cfg_hold_cycles = 8'd4;
    core(LL, LA, 1'b1); tick(); idle_all();
    snp(LA, 1'b1); tick(); idle_all();
    chk("R5 stall", snp_stall, 1);
    snp(LB, 1'b1); tick();
    chk("R5 refused e2", snp_out_valid, 0); tick();
    chk("R5 refused e3", snp_out_valid, 0); tick();
    chk("R4 expiry release", snp_out_valid, 1);
    chk("R4 expiry line", snp_out_line, LA);
    chk("R5 stall drop", snp_stall, 0);
    tick(); idle_all();
    chk("R5 second taken", snp_out_valid, 1);
    chk("R5 second line", snp_out_line, LB);
    tick();
    sc_expect(LA, 1'b0, "R4 after expiry");
    cfg_hold_cycles = 8'd40;
  endtask

  task automatic t_new_ll();
    core(LL, LA, 1'b1); tick(); idle_all();
    snp(LA, 1'b1); tick(); idle_all();
    core(LL, LB, 1'b1); tick(); idle_all();
    chk("R6 released", snp_out_valid, 1); chk("R6 line", snp_out_line, LA);
    chk("R6 stall", snp_stall, 0);
    sc_expect(LA, 1'b0, "R6 old line");
    core(LL, LA, 1'b0); tick(); core(LL, LB, 1'b0); tick(); idle_all();
    sc_expect(LB, 1'b1, "R6 new line");
  endtask

  task automatic t_pinned_collide();
    core(LL, LA, 1'b1); tick(); idle_all();
    core(SC, LA, 1'b0); snp(LA, 1'b1); tick(); idle_all();
    chk("R7 sc_ok", sc_ok, 1); chk("R7 out", snp_out_valid, 1);
    chk("R7 line", snp_out_line, LA); chk("R7 no stall", snp_stall, 0);
    tick();
  endtask

  task automatic t_store();
    core(LL, LA, 1'b1); tick(); core(ST, LA, 1'b0); tick(); idle_all();
    chk("R8 no result", sc_done, 0);
    sc_expect(LA, 1'b0, "R8 cleared");
    core(LL, LA, 1'b1); tick(); core(ST, LC, 1'b0); tick(); idle_all();
    sc_expect(LA, 1'b1, "R8 other line");
  endtask

  task automatic t_shared();
    core(LL, LA, 1'b0); tick(); idle_all();
    snp(LA, 1'b1); tick(); idle_all();
    chk("R9 pass", snp_out_valid, 1); chk("R9 no stall", snp_stall, 0);
    sc_expect(LA, 1'b0, "R9 killed");
    core(LL, LA, 1'b0); tick(); idle_all();
    snp(LA, 1'b0); tick(); idle_all();
    chk("R9 downgrade pass", snp_out_valid, 1);
    sc_expect(LA, 1'b1, "R9 downgrade kept");
    core(LL, LA, 1'b0); tick(); idle_all();
    core(SC, LA, 1'b0); snp(LA, 1'b1); tick(); idle_all();
    chk("R9 collide sc_ok", sc_ok, 0); chk("R9 collide out", snp_out_valid, 1);
    tick();
  endtask

  task automatic t_other_line();
    core(LL, LA, 1'b1); tick(); idle_all();
    snp(LB, 1'b1); tick(); idle_all();
    chk("R10 pass", snp_out_valid, 1); chk("R10 line", snp_out_line, LB);
    chk("R10 no stall", snp_stall, 0);
    sc_expect(LA, 1'b1, "R10 kept");
  endtask

  task automatic t_ll_kill();
    core(LL, LA, 1'b1); snp(LA, 1'b1); tick(); idle_all();
    chk("R11 out", snp_out_valid, 1);
    sc_expect(LA, 1'b0, "R11 no reservation");
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst = 1'b0; tick();
    t_reset();
    t_basic();
    t_pin_defer();
    t_window();
    t_expiry_backpressure();
    t_new_ll();
    t_pinned_collide();
    t_store();
    t_shared();
    t_other_line();
    t_ll_kill();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule